// File: doc/BRIEF.md
# Cyclic Dependency Address Acceptance Checker

This block sits beside one upstream port of an AXI crossbar and decides, cycle by cycle, whether the address currently offered on that port may be taken or must wait. Downstream targets may return responses out of order. Accepting an address that could close a circular wait between ports would deadlock the fabric, so the block stalls such addresses. It sees the request's ID and its already-decoded target index, the handshake that actually completes, and the final response for each ID. From these it keeps a record of what is still in flight.

A parameter picks one of three rule sets. Single-target keeps only a counter and the current target. Unique-ID and hybrid keep a small table of in-flight (ID, target) pairs. The output `req_ready` is meant to be ANDed into the address-channel ready, so a stall only removes ready and never discards an address that has already been taken. One instance serves one direction, either read or write.

Top module: `cdep_acceptor`

## Requirements
- R1: With nothing in flight and a legal configuration, `req_ready` is high for any ID and any target.
- R2: Single-target rule (SCHEME=CD_SINGLE). With work in flight, `req_ready` is high only when `req_tgt` equals the target of the work in flight.
- R3: Unique-ID rule (SCHEME=CD_UNIQUE). With work in flight, `req_ready` is high only when `req_id` equals no in-flight ID, whatever the target.
- R4: Hybrid rule (SCHEME=CD_HYBRID). With work in flight, `req_ready` is high when every in-flight entry has target `req_tgt`, or when `req_id` equals no in-flight ID.
- R5: When SCHEME is CD_UNIQUE or CD_HYBRID and ID_W is 0, `cfg_err` is 1 and `req_ready` stays 0. Otherwise `cfg_err` is 0.
- R6: At most MAX_OUT transactions are in flight. When MAX_OUT are outstanding, `req_ready` is 0 under every rule.
- R7: A `rsp_done` pulse retires one transaction.
  - In the table rules it frees the lowest-numbered valid entry whose ID equals `rsp_id`. A pulse whose ID matches no entry changes nothing.
  - In the single-target rule it decrements a nonzero count and ignores `rsp_id`.
- R8: When an accepted address (`acc_fire` with `req_valid`) and a `rsp_done` fall in the same cycle, both take effect. The in-flight record is unchanged in size and now holds the new transaction.
- R9: A stall only lowers `req_ready`. Every completed handshake is recorded, `acc_fire` is only legal while `req_ready` is high, and reset empties the record.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Address valid on the upstream port |
| req_id | input | max(ID_W,1) | ID of the offered address |
| req_tgt | input | TGT_W | Decoded target index of the offered address |
| acc_fire | input | 1 | Address handshake completed this cycle |
| rsp_done | input | 1 | Final response for one transaction returned |
| rsp_id | input | max(ID_W,1) | ID carried by that final response |
| req_ready | output | 1 | Acceptance permission, combinational from state and request |
| cfg_err | output | 1 | Illegal parameter combination |

## Verification
A corrupt in-flight record appears at `req_ready` in the very next cycle after the faulty update, because ready is combinational from the stored state.

- A lost entry shows up as a request wrongly accepted, either a repeated ID or a foreign target.
- A stuck entry shows up as a permanent stall once the limit is reached.
- A wrong free on a simultaneous response and acceptance shows up one or two requests later, as a wrong accept or stall decision for a known ID.

The stimulus drives the three rules in parallel through the same sequence, so that each divergence is visible in a single cycle.

// File: rtl/cdep_pkg.sv
package cdep_pkg;

   typedef enum logic [1:0] {
      CD_SINGLE = 2'd0,
      CD_UNIQUE = 2'd1,
      CD_HYBRID = 2'd2
   } cdep_scheme_e;

endpackage

// File: rtl/cdep_tgt_track.sv
module cdep_tgt_track #(
   parameter int TGT_W = 2,
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic [TGT_W-1:0] take_tgt,
   input  logic             retire,
   input  logic [TGT_W-1:0] req_tgt,
   output logic [CNT_W-1:0] cnt,
   output logic             tgt_match
);

   logic [CNT_W-1:0] cnt_q;
   logic [TGT_W-1:0] tgt_q;
   logic             dec;

   assign dec       = retire && (cnt_q != '0);
   assign cnt       = cnt_q;
   assign tgt_match = (tgt_q == req_tgt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tgt_q <= '0;
      end else begin
         case ({take, dec})
            2'b10:   cnt_q <= cnt_q + CNT_W'(1);
            2'b01:   cnt_q <= cnt_q - CNT_W'(1);
            default: cnt_q <= cnt_q;
         endcase
         if (take && (cnt_q == '0))
            tgt_q <= take_tgt;
      end
   end

endmodule

// File: rtl/cdep_id_table.sv
module cdep_id_table #(
   parameter int ID_W  = 3,
   parameter int TGT_W = 2,
   parameter int DEPTH = 4,
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic [ID_W-1:0]  take_id,
   input  logic [TGT_W-1:0] take_tgt,
   input  logic             retire,
   input  logic [ID_W-1:0]  retire_id,
   input  logic [ID_W-1:0]  req_id,
   input  logic [TGT_W-1:0] req_tgt,
   output logic [CNT_W-1:0] cnt,
   output logic             id_hit,
   output logic             tgt_uniform
);

   logic [DEPTH-1:0] vld;
   logic [ID_W-1:0]  ent_id  [DEPTH];
   logic [TGT_W-1:0] ent_tgt [DEPTH];
   logic [DEPTH-1:0] rsp_match;
   logic [DEPTH-1:0] req_match;
   logic [DEPTH-1:0] tgt_diff;
   logic [DEPTH-1:0] empty_v;
   logic [DEPTH-1:0] alloc_oh;
   logic [DEPTH-1:0] free_oh;

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      assign rsp_match[i] = vld[i] && (ent_id[i] == retire_id);
      assign req_match[i] = vld[i] && (ent_id[i] == req_id);
      assign tgt_diff[i]  = vld[i] && (ent_tgt[i] != req_tgt);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld[i]     <= 1'b0;
            ent_id[i]  <= '0;
            ent_tgt[i] <= '0;
         end else if (take && alloc_oh[i]) begin
            vld[i]     <= 1'b1;
            ent_id[i]  <= take_id;
            ent_tgt[i] <= take_tgt;
         end else if (retire && free_oh[i]) begin
            vld[i]     <= 1'b0;
         end
      end
   end

   assign empty_v  = ~vld;
   assign alloc_oh = empty_v & (~empty_v + DEPTH'(1));
   assign free_oh  = rsp_match & (~rsp_match + DEPTH'(1));

   assign id_hit      = |req_match;
   assign tgt_uniform = ~|tgt_diff;

   always_comb begin
      cnt = '0;
      for (int i = 0; i < DEPTH; i++)
         cnt = cnt + CNT_W'(vld[i]);
   end

endmodule

// File: rtl/cdep_acceptor.sv
module cdep_acceptor
   import cdep_pkg::*;
#(
   parameter cdep_scheme_e SCHEME  = CD_HYBRID,
   parameter int           ID_W    = 3,
   parameter int           TGT_W   = 2,
   parameter int           MAX_OUT = 4,
   localparam int          IDW_P   = (ID_W > 0) ? ID_W : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [IDW_P-1:0] req_id,
   input  logic [TGT_W-1:0] req_tgt,
   input  logic             acc_fire,
   input  logic             rsp_done,
   input  logic [IDW_P-1:0] rsp_id,
   output logic             req_ready,
   output logic             cfg_err
);

   localparam int   CNT_W   = $clog2(MAX_OUT + 1);
   localparam logic NEED_ID = (SCHEME != CD_SINGLE);
   localparam logic BAD_CFG = NEED_ID && (ID_W == 0);
   localparam logic USE_TGT = (SCHEME != CD_UNIQUE);
   localparam logic USE_ID  = (SCHEME != CD_SINGLE);

   if (MAX_OUT < 1) begin : g_bad_depth
      $error("cdep_acceptor: MAX_OUT must be at least 1");
   end
   if (TGT_W < 1) begin : g_bad_tgt
      $error("cdep_acceptor: TGT_W must be at least 1");
   end

   logic             take;
   logic [CNT_W-1:0] occ_cnt;
   logic             same_tgt;
   logic             id_hit;
   logic             rule_ok;

   assign take = acc_fire && req_valid;

   if (SCHEME == CD_SINGLE) begin : g_single
      logic unused_ids;
      assign unused_ids = ^{req_id, rsp_id};
      assign id_hit     = 1'b1;

      cdep_tgt_track #(
         .TGT_W (TGT_W),
         .CNT_W (CNT_W)
      ) u_track (
         .clk       (clk),
         .rst_n     (rst_n),
         .take      (take),
         .take_tgt  (req_tgt),
         .retire    (rsp_done),
         .req_tgt   (req_tgt),
         .cnt       (occ_cnt),
         .tgt_match (same_tgt)
      );
   end else begin : g_table
      cdep_id_table #(
         .ID_W  (IDW_P),
         .TGT_W (TGT_W),
         .DEPTH (MAX_OUT),
         .CNT_W (CNT_W)
      ) u_table (
         .clk         (clk),
         .rst_n       (rst_n),
         .take        (take),
         .take_id     (req_id),
         .take_tgt    (req_tgt),
         .retire      (rsp_done),
         .retire_id   (rsp_id),
         .req_id      (req_id),
         .req_tgt     (req_tgt),
         .cnt         (occ_cnt),
         .id_hit      (id_hit),
         .tgt_uniform (same_tgt)
      );
   end

   assign rule_ok = (occ_cnt == '0)
                  || (USE_TGT && same_tgt)
                  || (USE_ID && !id_hit);

   assign cfg_err   = BAD_CFG;
   assign req_ready = !BAD_CFG && (occ_cnt < CNT_W'(MAX_OUT)) && rule_ok;

endmodule

// File: rtl/cdep_acceptor_chk.sv
module cdep_acceptor_chk #(
   parameter int MAX_OUT = 4,
   parameter int CNT_W   = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             acc_fire,
   input logic             rsp_done,
   input logic             cfg_err,
   input logic [CNT_W-1:0] cnt
);

   p_fire_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      acc_fire |-> (req_valid && req_ready));

   p_cfg_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !req_ready);

   p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(MAX_OUT));

   p_full_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_W'(MAX_OUT)) |-> !req_ready);

   p_empty_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt == '0) && !cfg_err) |-> req_ready);

   p_take_grows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_fire && req_valid && !rsp_done) |=> (cnt == $past(cnt) + CNT_W'(1)));

   p_idle_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_fire && !rsp_done) |=> $stable(cnt));

   p_swap_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_fire && req_valid && rsp_done && (cnt != '0)) |=> $stable(cnt));

endmodule

bind cdep_acceptor cdep_acceptor_chk #(
   .MAX_OUT (MAX_OUT),
   .CNT_W   (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .acc_fire  (acc_fire),
   .rsp_done  (rsp_done),
   .cfg_err   (cfg_err),
   .cnt       (occ_cnt)
);

// File: tb/cdep_acceptor_test.sv
`timescale 1ns/1ps
module cdep_acceptor_test;
   import cdep_pkg::*;

   localparam int ID_W  = 3;
   localparam int TGT_W = 2;
   localparam int MAXO  = 3;

   // vector: acc, id[3], tgt[2], done, done_id[3], exp single, exp unique, exp hybrid
   localparam logic [12:0] VEC [0:11] = '{
      {1'b1, 3'd1, 2'd0, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1},  // R1 empty
      {1'b1, 3'd2, 2'd1, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1},  // R2 R3 R4
      {1'b1, 3'd1, 2'd0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0},  // R2 R3 R4
      {1'b1, 3'd3, 2'd0, 1'b1, 3'd2, 1'b1, 1'b1, 1'b1},  // R8
      {1'b1, 3'd1, 2'd0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b1},  // R4 same target
      {1'b1, 3'd4, 2'd2, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0},  // R6
      {1'b1, 3'd5, 2'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0},  // R6 all full
      {1'b0, 3'd5, 2'd0, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0},  // R7
      {1'b0, 3'd1, 2'd1, 1'b1, 3'd7, 1'b0, 1'b1, 1'b0},  // R7 stray id
      {1'b1, 3'd6, 2'd1, 1'b1, 3'd3, 1'b0, 1'b1, 1'b1},  // R8
      {1'b1, 3'd4, 2'd3, 1'b0, 3'd0, 1'b1, 1'b0, 1'b1},  // R1 R3
      {1'b0, 3'd0, 2'd3, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0}   // R2 R6
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic [ID_W-1:0]  req_id = '0;
   logic [TGT_W-1:0] req_tgt = '0;
   logic             rsp_done = 1'b0;
   logic [ID_W-1:0]  rsp_id = '0;
   logic             fire_s = 1'b0, fire_u = 1'b0, fire_h = 1'b0;
   logic             rdy_s, rdy_u, rdy_h, rdy_e;
   logic             err_s, err_u, err_h, err_e;
   int               checks = 0;
   int               failures = 0;
   bit               finished = 1'b0;

   always #10 clk = ~clk;

   cdep_acceptor #(.SCHEME(CD_SINGLE), .ID_W(ID_W), .TGT_W(TGT_W), .MAX_OUT(MAXO)) uut_s (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id), .req_tgt(req_tgt),
      .acc_fire(fire_s), .rsp_done(rsp_done), .rsp_id(rsp_id), .req_ready(rdy_s), .cfg_err(err_s));

   cdep_acceptor #(.SCHEME(CD_UNIQUE), .ID_W(ID_W), .TGT_W(TGT_W), .MAX_OUT(MAXO)) uut_u (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id), .req_tgt(req_tgt),
      .acc_fire(fire_u), .rsp_done(rsp_done), .rsp_id(rsp_id), .req_ready(rdy_u), .cfg_err(err_u));

   cdep_acceptor #(.SCHEME(CD_HYBRID), .ID_W(ID_W), .TGT_W(TGT_W), .MAX_OUT(MAXO)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id), .req_tgt(req_tgt),
      .acc_fire(fire_h), .rsp_done(rsp_done), .rsp_id(rsp_id), .req_ready(rdy_h), .cfg_err(err_h));

   cdep_acceptor #(.SCHEME(CD_UNIQUE), .ID_W(0), .TGT_W(TGT_W), .MAX_OUT(MAXO)) uut_e (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(1'b0), .req_tgt(req_tgt),
      .acc_fire(1'b0), .rsp_done(rsp_done), .rsp_id(1'b0), .req_ready(rdy_e), .cfg_err(err_e));

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n     = 1'b1;
      req_valid = 1'b1;
      req_id    = 3'd5;
      req_tgt   = 2'd2;
      #1;
      chk("R1 reset single ready", rdy_s, 1'b1);
      chk("R1 reset unique ready", rdy_u, 1'b1);
      chk("R1 reset hybrid ready", rdy_h, 1'b1);
      chk("R5 illegal config flag", err_e, 1'b1);
      chk("R5 illegal config stalls", rdy_e, 1'b0);
      chk("R5 legal config no flag", err_h | err_u | err_s, 1'b0);

      for (int k = 0; k < 12; k++) begin
         logic [12:0] v;
         v = VEC[k];
         @(negedge clk);
         req_id   = v[11:9];
         req_tgt  = v[8:7];
         rsp_done = v[6];
         rsp_id   = v[5:3];
         #1;
         chk($sformatf("R2 single step %0d", k), rdy_s, v[2]);
         chk($sformatf("R3 unique step %0d", k), rdy_u, v[1]);
         chk($sformatf("R4 hybrid step %0d", k), rdy_h, v[0]);
         fire_s = v[12] & v[2];
         fire_u = v[12] & v[1];
         fire_h = v[12] & v[0];
         @(posedge clk);
         #1;
         fire_s = 1'b0; fire_u = 1'b0; fire_h = 1'b0;
         rsp_done = 1'b0;
      end

      // R9: reset mid-run empties every record
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rst_n   = 1'b1;
      req_id  = 3'd4;
      req_tgt = 2'd1;
      #1;
      chk("R9 reset clears single", rdy_s, 1'b1);
      chk("R9 reset clears unique", rdy_u, 1'b1);
      chk("R9 reset clears hybrid", rdy_h, 1'b1);
      chk("R5 flag persists after reset", err_e, 1'b1);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL R9 watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule